// File: doc/BRIEF.md
# Breaking-Event Address Tracker

This block keeps a 64-bit record of the most recent instruction that diverted the processor from sequential flow. It watches a retire interface that delivers one instruction per cycle. Each retired instruction carries its address, a flag saying that it was a branch that was taken, a flag saying that it ran as the subject of an Execute instruction, and the address of that Execute instruction. When a taken branch retires, the record is overwritten. The new value is the branch's own address, or the Execute instruction's address when the branch ran under an Execute.

A one-cycle interrupt strobe makes the block save the record to memory. It raises a doubleword store request aimed at the fixed low-storage location 272. The request keeps its address and data steady until the memory side accepts it with a valid/ready handshake. A read port shows the live register value at all times. The asynchronous active-low reset is released through an internal synchronizer.

Top module: `brk_event_tracker`

## Requirements
- R1: While reset is active, and right after it, the read port `bea_rd` is zero and `st_valid` is low.
- R2: A retire with `ret_valid`=1, `ret_taken`=1 and `ret_under_exec`=0 sets `bea_rd` to `ret_iaddr`. The new value is visible from the cycle after the retire.
- R3: A retire with `ret_valid`=1, `ret_taken`=1 and `ret_under_exec`=1 sets `bea_rd` to `ret_exec_iaddr`, not to `ret_iaddr`. The new value is visible from the cycle after the retire.
- R4: If `ret_valid`=0 or `ret_taken`=0, `bea_rd` does not change, whatever the other retire fields hold.
- R5: An `irq_strobe` pulse when no request is outstanding raises `st_valid` in the next cycle. The request then carries `st_addr` = 272 and `st_data` equal to the register value.
- R6: If a taken branch retires in the same cycle as `irq_strobe`, `st_data` carries the address that this branch recorded.
- R7: While `st_valid`=1 and `st_ready`=0, `st_valid`, `st_addr` and `st_data` stay unchanged, even if the register is updated meanwhile. After a cycle with `st_valid`=1 and `st_ready`=1 and no new strobe, `st_valid` is low.
- R8: An `irq_strobe` pulse that arrives while a request is outstanding and not accepted in that cycle is dropped. The pending request keeps its original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| ret_valid | input | 1 | A retired instruction is present this cycle |
| ret_taken | input | 1 | The retired instruction is a taken branch |
| ret_under_exec | input | 1 | The retired instruction ran as the subject of an Execute |
| ret_iaddr | input | 64 | Address of the retired instruction |
| ret_exec_iaddr | input | 64 | Address of the Execute instruction that ran it |
| irq_strobe | input | 1 | One-cycle interrupt pulse that requests a save |
| st_valid | output | 1 | A store request is pending |
| st_ready | input | 1 | The memory side accepts the request |
| st_addr | output | 64 | Store address (fixed at 272) |
| st_data | output | 64 | Doubleword to be stored |
| bea_rd | output | 64 | Current register value |

## Verification
Two events can land in the same cycle: a taken-branch retire and an interrupt strobe. The bench provokes this by driving both on one clock edge, for both an Execute-subject branch and a plain branch. It then checks that the resulting request data equals the newly recorded address and not the older one. The bench also lines up a strobe with a request that has not yet been accepted, and a register update with a request that is stalled. In each case it judges that the request data stays unchanged until the handshake.

// File: rtl/bea_pkg.sv
package bea_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_OWN  = 2'd1,
    SRC_EXEC = 2'd2
  } bea_src_e;

  localparam int unsigned DEF_ADDR_W    = 64;
  localparam int unsigned DEF_SAVE_ADDR = 272;
endpackage

// File: rtl/bea_rst_sync.sv
module bea_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bea_src_decode.sv
module bea_src_decode
  import bea_pkg::*;
(
  input  logic     ret_valid,
  input  logic     ret_taken,
  input  logic     ret_under_exec,
  output bea_src_e src_sel
);
  always_comb begin
    src_sel = SRC_HOLD;
    if (ret_valid && ret_taken) begin
      src_sel = ret_under_exec ? SRC_EXEC : SRC_OWN;
    end
  end
endmodule

// File: rtl/bea_capture.sv
module bea_capture
  import bea_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bea_src_e          src_sel,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] exec_addr,
  output logic [ADDR_W-1:0] bea_nxt,
  output logic [ADDR_W-1:0] bea_q
);
  logic bea_en;

  always_comb begin
    bea_en  = 1'b0;
    bea_nxt = bea_q;
    unique case (src_sel)
      SRC_OWN: begin
        bea_en  = 1'b1;
        bea_nxt = own_addr;
      end
      SRC_EXEC: begin
        bea_en  = 1'b1;
        bea_nxt = exec_addr;
      end
      default: begin
        bea_en  = 1'b0;
        bea_nxt = bea_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bea_q <= '0;
    else if (bea_en) bea_q <= bea_nxt;
  end
endmodule

// File: rtl/bea_store_req.sv
module bea_store_req #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned SAVE_ADDR = 272
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_strobe,
  input  logic [ADDR_W-1:0] save_value,
  input  logic              st_ready,
  output logic              st_valid,
  output logic [ADDR_W-1:0] st_addr,
  output logic [ADDR_W-1:0] st_data
);
  localparam logic [ADDR_W-1:0] SAVE_LOC = ADDR_W'(SAVE_ADDR);

  logic              accept;
  logic              load;
  logic              valid_nxt;
  logic              valid_en;
  logic              data_en;
  logic [ADDR_W-1:0] data_q;

  always_comb begin
    accept    = st_valid && st_ready;
    load      = irq_strobe && (!st_valid || accept);
    valid_en  = load || accept;
    valid_nxt = load;
    data_en   = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_valid <= 1'b0;
    else if (valid_en) st_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= save_value;
  end

  assign st_data = data_q;
  assign st_addr = SAVE_LOC;
endmodule

// File: rtl/brk_event_tracker.sv
module brk_event_tracker
  import bea_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SAVE_ADDR   = DEF_SAVE_ADDR,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic              ret_taken,
  input  logic              ret_under_exec,
  input  logic [ADDR_W-1:0] ret_iaddr,
  input  logic [ADDR_W-1:0] ret_exec_iaddr,
  input  logic              irq_strobe,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [ADDR_W-1:0] st_addr,
  output logic [ADDR_W-1:0] st_data,
  output logic [ADDR_W-1:0] bea_rd
);
  logic              rst_sync_n;
  bea_src_e          src_sel;
  logic [ADDR_W-1:0] bea_nxt;
  logic [ADDR_W-1:0] bea_q;

  bea_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bea_src_decode u_dec (
    .ret_valid      (ret_valid),
    .ret_taken      (ret_taken),
    .ret_under_exec (ret_under_exec),
    .src_sel        (src_sel)
  );

  bea_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_sel   (src_sel),
    .own_addr  (ret_iaddr),
    .exec_addr (ret_exec_iaddr),
    .bea_nxt   (bea_nxt),
    .bea_q     (bea_q)
  );

  // The save path takes the next-state value so a same-cycle branch is included.
  bea_store_req #(.ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR)) u_st (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .irq_strobe (irq_strobe),
    .save_value (bea_nxt),
    .st_ready   (st_ready),
    .st_valid   (st_valid),
    .st_addr    (st_addr),
    .st_data    (st_data)
  );

  assign bea_rd = bea_q;
endmodule

// File: rtl/brk_event_tracker_chk.sv
module brk_event_tracker_chk #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_valid,
  input logic              ret_taken,
  input logic              ret_under_exec,
  input logic [ADDR_W-1:0] ret_iaddr,
  input logic [ADDR_W-1:0] ret_exec_iaddr,
  input logic              irq_strobe,
  input logic              st_valid,
  input logic              st_ready,
  input logic [ADDR_W-1:0] st_data,
  input logic [ADDR_W-1:0] bea_rd
);
  a_r2_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_taken && !ret_under_exec) |=> (bea_rd == $past(ret_iaddr)));

  a_r3_exec_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_taken && ret_under_exec) |=> (bea_rd == $past(ret_exec_iaddr)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_valid && ret_taken) |=> $stable(bea_rd));

  // R5 and R6: the saved doubleword equals the value the register took at the same edge
  a_r6_save_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_strobe && (!st_valid || st_ready)) |=> (st_valid && st_data == bea_rd));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !irq_strobe) |=> !st_valid);
endmodule

bind brk_event_tracker brk_event_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .ret_valid      (ret_valid),
  .ret_taken      (ret_taken),
  .ret_under_exec (ret_under_exec),
  .ret_iaddr      (ret_iaddr),
  .ret_exec_iaddr (ret_exec_iaddr),
  .irq_strobe     (irq_strobe),
  .st_valid       (st_valid),
  .st_ready       (st_ready),
  .st_data        (st_data),
  .bea_rd         (bea_rd)
);

// File: tb/tb_brk_event_tracker.sv
`timescale 1ns/1ps
module tb_brk_event_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic        ret_taken = 1'b0;
  logic        ret_under_exec = 1'b0;
  logic [63:0] ret_iaddr = '0;
  logic [63:0] ret_exec_iaddr = '0;
  logic        irq_strobe = 1'b0;
  logic        st_ready = 1'b0;
  logic        st_valid;
  logic [63:0] st_addr;
  logic [63:0] st_data;
  logic [63:0] bea_rd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  brk_event_tracker dut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_taken(ret_taken),
    .ret_under_exec(ret_under_exec), .ret_iaddr(ret_iaddr),
    .ret_exec_iaddr(ret_exec_iaddr), .irq_strobe(irq_strobe),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .bea_rd(bea_rd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        v;
    logic        t;
    logic        x;
    logic [63:0] ia;
    logic [63:0] ea;
    logic [63:0] expv;
  } vec_t;

  // Retire patterns, expected register value after each one
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b1, 1'b0, 64'h1000, 64'hAAAA, 64'h1000},                                   // R2
    '{1'b1, 1'b0, 1'b0, 64'h2000, 64'hBBBB, 64'h1000},                                   // R4 not taken
    '{1'b0, 1'b1, 1'b1, 64'h3000, 64'hCCCC, 64'h1000},                                   // R4 no retire
    '{1'b1, 1'b1, 1'b1, 64'h4000, 64'h5000, 64'h5000},                                   // R3
    '{1'b1, 1'b0, 1'b1, 64'h6000, 64'h7000, 64'h5000},                                   // R4
    '{1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 64'hFFFF_FFFF_FFFF_FFFE},        // R2
    '{1'b1, 1'b1, 1'b1, 64'h10, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0002},       // R3
    '{1'b1, 1'b1, 1'b0, 64'h0, 64'h9, 64'h0}                                             // R2
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic retire(input logic v, input logic t, input logic x,
                        input logic [63:0] ia, input logic [63:0] ea);
    ret_valid = v; ret_taken = t; ret_under_exec = x;
    ret_iaddr = ia; ret_exec_iaddr = ea;
  endtask

  task automatic idle();
    retire(1'b0, 1'b0, 1'b0, '0, '0);
    irq_strobe = 1'b0;
  endtask

  // Drive happens at a negedge; this advances to the next negedge, past one rising edge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    chk("R1 bea_rd in reset", bea_rd, 64'h0);
    chk("R1 st_valid in reset", {63'h0, st_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 bea_rd after reset", bea_rd, 64'h0);
    chk("R1 st_valid after reset", {63'h0, st_valid}, 64'h0);

    // Vector walk: R2, R3, R4
    for (int i = 0; i < 8; i++) begin
      retire(VEC[i].v, VEC[i].t, VEC[i].x, VEC[i].ia, VEC[i].ea);
      step();
      idle();
      chk($sformatf("R2/R3/R4 vector %0d", i), bea_rd, VEC[i].expv);
    end

    // R5: strobe alone
    retire(1'b1, 1'b1, 1'b0, 64'h1234, 64'h0);
    step();
    idle();
    irq_strobe = 1'b1;
    step();
    irq_strobe = 1'b0;
    chk("R5 st_valid", {63'h0, st_valid}, 64'h1);
    chk("R5 st_addr", st_addr, 64'd272);
    chk("R5 st_data", st_data, 64'h1234);

    // R7: stall with register update in between
    retire(1'b1, 1'b1, 1'b1, 64'h1, 64'hBEEF);
    step();
    idle();
    chk("R7 register still updates", bea_rd, 64'hBEEF);
    chk("R7 st_data held", st_data, 64'h1234);
    chk("R7 st_valid held", {63'h0, st_valid}, 64'h1);

    // R8: strobe while pending is dropped
    irq_strobe = 1'b1;
    step();
    irq_strobe = 1'b0;
    step();
    chk("R8 st_data kept", st_data, 64'h1234);
    chk("R8 st_addr kept", st_addr, 64'd272);

    // R7: handshake releases
    st_ready = 1'b1;
    step();
    st_ready = 1'b0;
    chk("R7 st_valid drops after accept", {63'h0, st_valid}, 64'h0);
    step();
    chk("R8 dropped strobe left nothing", {63'h0, st_valid}, 64'h0);

    // R6: branch under Execute with strobe in same cycle
    retire(1'b1, 1'b1, 1'b1, 64'h7777, 64'h9990);
    irq_strobe = 1'b1;
    step();
    idle();
    chk("R6 st_data includes same-cycle branch", st_data, 64'h9990);
    chk("R6 register", bea_rd, 64'h9990);

    // Accept and re-arm on the same edge, with a plain branch (R6 and R7)
    st_ready = 1'b1;
    retire(1'b1, 1'b1, 1'b0, 64'hABC0, 64'h0);
    irq_strobe = 1'b1;
    step();
    idle();
    st_ready = 1'b0;
    chk("R7 re-armed st_valid", {63'h0, st_valid}, 64'h1);
    chk("R6 re-armed st_data", st_data, 64'hABC0);
    st_ready = 1'b1;
    step();
    st_ready = 1'b0;
    chk("R7 released", {63'h0, st_valid}, 64'h0);

    // R1: reset in mid-run clears the register
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset clears register", bea_rd, 64'h0);
    step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 st_valid after mid-run reset", {63'h0, st_valid}, 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule